// File: doc/BRIEF.md
# UART Host Port FIFO Bridge

This block sits between a host data port and a conventional UART core. With the deep-FIFO mode enabled, a host write to the data port is pushed into a transmit FIFO, and a host read pops the oldest byte of a receive FIFO. Independently of the host, the bridge moves the transmit FIFO's head byte into the UART transmitter whenever the UART's holding register is empty. It also moves each byte the UART has received into the receive FIFO. With the mode disabled, the data port is wired straight through to the UART, as if the bridge were absent.

Two bits of the modem-control output register stop each transfer direction on its own. These bits let software pause draining or filling without losing queued bytes. Both FIFOs report empty, half-full and full levels, with the receive full level given active low. A single clear strobe discards the contents of both FIFOs.

Top module: `uart_fifo_bridge`

## Requirements
- R1: After reset both FIFOs are empty: tx_empty=1, rx_empty=1, tx_half=0, rx_half=0, tx_full=0, rx_full_n=1.
- R2: With fifo_mode=0, uart_tx_load follows host_wr and uart_tx_data follows host_wdata in the same cycle. uart_rx_take follows host_rd and host_rdata follows uart_rx_data. Neither FIFO changes.
- R3: With fifo_mode=1, each host_wr pushes host_wdata into the transmit FIFO. Bytes leave in write order on uart_tx_data, one per cycle, with uart_tx_load high in that cycle.
- R4: A byte moves from the transmit FIFO to the UART only in a cycle with uart_thr_empty=1.
- R5: While mctl[2]=1 in FIFO mode, uart_tx_load stays low and queued transmit bytes are kept.
- R6: With fifo_mode=1, mctl[3]=0, uart_rx_ready=1 and space in the receive FIFO, uart_rx_take is high and uart_rx_data is stored. host_rdata shows the oldest stored byte, and it is removed at the clock edge of a cycle with host_rd=1.
- R7: While mctl[3]=1 in FIFO mode, uart_rx_take stays low and the receive FIFO is not filled.
- R8: For each FIFO, with count c and capacity D: empty is c==0, half is c>=D/2, full is c==D. The receive full level is output active low on rx_full_n.
- R9: A host write to a full transmit FIFO is dropped. A full receive FIFO takes no byte from the UART (uart_rx_take=0).
- R10: A host read of an empty receive FIFO in FIFO mode returns 0 and leaves the FIFO empty.
- R11: fifo_clr=1 empties both FIFOs at the next clock edge. No byte is passed to or taken from the UART in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | 1 routes the data port through the FIFOs |
| mctl | input | 4 | Modem-control bits; bit3 stops receive fill, bit2 stops transmit drain |
| host_wr | input | 1 | Host write strobe at the data port |
| host_wdata | input | DW | Host write byte |
| host_rd | input | 1 | Host read strobe at the data port |
| host_rdata | output | DW | Host read byte |
| fifo_clr | input | 1 | Clear strobe for both FIFOs |
| uart_thr_empty | input | 1 | UART transmit holding register empty |
| uart_tx_load | output | 1 | Load strobe into the UART transmitter |
| uart_tx_data | output | DW | Byte to the UART transmitter |
| uart_rx_ready | input | 1 | UART holds a received byte |
| uart_rx_data | input | DW | Received byte from the UART |
| uart_rx_take | output | 1 | Removes the received byte from the UART |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_half | output | 1 | Transmit FIFO at least half full |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_half | output | 1 | Receive FIFO at least half full |
| rx_full_n | output | 1 | Receive FIFO full, active low |

## Verification
The assertions check the following on every cycle:
- the gating of both transfer directions by mctl and uart_thr_empty;
- the ordering among the level flags;
- that a full transmit FIFO stays full while nothing drains it;
- the zero returned by an empty read;
- the emptiness after a clear.

Byte order through each FIFO, the exact thresholds of the half and full levels, and the pass-through in direct mode need the bench's scenarios. In those scenarios known byte sequences are queued, held and drained.

// File: rtl/uart_fifo_bridge.sv
module uart_fifo_bridge #(
  parameter int DW       = 8,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic [3:0]    mctl,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          fifo_clr,
  input  logic          uart_thr_empty,
  output logic          uart_tx_load,
  output logic [DW-1:0] uart_tx_data,
  input  logic          uart_rx_ready,
  input  logic [DW-1:0] uart_rx_data,
  output logic          uart_rx_take,
  output logic          tx_empty,
  output logic          tx_half,
  output logic          tx_full,
  output logic          rx_empty,
  output logic          rx_half,
  output logic          rx_full_n
);
  localparam int TAW = $clog2(TX_DEPTH);
  localparam int RAW = $clog2(RX_DEPTH);
  localparam logic [TAW:0] TX_CAP  = (TAW+1)'(TX_DEPTH);
  localparam logic [TAW:0] TX_HALF = (TAW+1)'(TX_DEPTH/2);
  localparam logic [RAW:0] RX_CAP  = (RAW+1)'(RX_DEPTH);
  localparam logic [RAW:0] RX_HALF = (RAW+1)'(RX_DEPTH/2);

  logic [DW-1:0] tx_mem [TX_DEPTH];
  logic [DW-1:0] rx_mem [RX_DEPTH];
  logic [TAW:0]  tx_wp, tx_rp, tx_cnt;
  logic [RAW:0]  rx_wp, rx_rp, rx_cnt;
  logic          tx_push, tx_pop, rx_push, rx_pop;

  assign tx_cnt   = tx_wp - tx_rp;
  assign rx_cnt   = rx_wp - rx_rp;
  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == TX_CAP);
  assign tx_half  = (tx_cnt >= TX_HALF);
  assign rx_empty = (rx_cnt == '0);
  assign rx_full_n = (rx_cnt != RX_CAP);
  assign rx_half  = (rx_cnt >= RX_HALF);

  assign tx_push = fifo_mode & host_wr & ~tx_full & ~fifo_clr;
  assign tx_pop  = fifo_mode & ~mctl[2] & uart_thr_empty & ~tx_empty & ~fifo_clr;
  assign rx_push = fifo_mode & ~mctl[3] & uart_rx_ready & rx_full_n & ~fifo_clr;
  assign rx_pop  = fifo_mode & host_rd & ~rx_empty & ~fifo_clr;

  assign uart_tx_load = fifo_mode ? tx_pop : host_wr;
  assign uart_tx_data = fifo_mode ? tx_mem[tx_rp[TAW-1:0]] : host_wdata;
  assign uart_rx_take = fifo_mode ? rx_push : host_rd;
  assign host_rdata   = !fifo_mode ? uart_rx_data
                      : rx_empty ? '0 : rx_mem[rx_rp[RAW-1:0]];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[TAW-1:0]] <= host_wdata;
    if (rx_push) rx_mem[rx_wp[RAW-1:0]] <= uart_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      rx_wp <= '0;
      rx_rp <= '0;
    end else if (fifo_clr) begin
      tx_wp <= '0;
      tx_rp <= '0;
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end
  end
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic [3:0]    mctl,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic          fifo_clr,
  input logic          uart_thr_empty,
  input logic          uart_tx_load,
  input logic          uart_rx_take,
  input logic          tx_empty,
  input logic          tx_half,
  input logic          tx_full,
  input logic          rx_empty,
  input logic          rx_half,
  input logic          rx_full_n
);
  // R4
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && uart_tx_load |-> uart_thr_empty);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && mctl[2] |-> !uart_tx_load);
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && mctl[3] |-> !uart_rx_take);
  // R8
  tx_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> tx_half && !tx_empty);
  // R8
  rx_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_full_n |-> rx_half && !rx_empty);
  // R9
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && tx_full && !uart_tx_load && !fifo_clr |=> tx_full);
  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && host_rd && rx_empty |-> host_rdata == '0);
  // R11
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> tx_empty && rx_empty);
  // R6
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && rx_empty && uart_rx_take && !fifo_clr |=> !rx_empty);
endmodule

bind uart_fifo_bridge bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .mctl(mctl),
  .host_rd(host_rd), .host_rdata(host_rdata), .fifo_clr(fifo_clr),
  .uart_thr_empty(uart_thr_empty), .uart_tx_load(uart_tx_load),
  .uart_rx_take(uart_rx_take), .tx_empty(tx_empty), .tx_half(tx_half),
  .tx_full(tx_full), .rx_empty(rx_empty), .rx_half(rx_half),
  .rx_full_n(rx_full_n));

// File: tb/tb_uart_fifo_bridge.sv
module tb_uart_fifo_bridge;
  logic clk = 0, rst_n = 0, fifo_mode = 0, host_wr = 0, host_rd = 0, fifo_clr = 0;
  logic uart_thr_empty = 0, uart_rx_ready = 0;
  logic [3:0] mctl = 0;
  logic [7:0] host_wdata = 0, uart_rx_data = 0;
  logic [7:0] host_rdata, uart_tx_data;
  logic uart_tx_load, uart_rx_take, tx_empty, tx_half, tx_full, rx_empty, rx_half, rx_full_n;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [7:0] VEC [8] = '{8'h5A, 8'hC3, 8'h01, 8'hFE, 8'h77, 8'h80, 8'h3D, 8'h92};

  uart_fifo_bridge dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  function automatic logic [7:0] txb(input int i);
    return (i < 8) ? VEC[i] : VEC[i-8] ^ 8'hFF;
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    eq("R1 tx_empty", tx_empty, 1); eq("R1 rx_empty", rx_empty, 1);
    eq("R1 tx_half", tx_half, 0);   eq("R1 rx_half", rx_half, 0);
    eq("R1 tx_full", tx_full, 0);   eq("R1 rx_full_n", rx_full_n, 1);

    // R2 direct mode
    host_wr = 1; host_wdata = 8'hA5; host_rd = 1; uart_rx_data = 8'h3C; #1;
    eq("R2 load", uart_tx_load, 1); eq("R2 txdata", uart_tx_data, 8'hA5);
    eq("R2 take", uart_rx_take, 1); eq("R2 rdata", host_rdata, 8'h3C);
    @(negedge clk); host_wr = 0; host_rd = 0; #1;
    eq("R2 tx untouched", tx_empty, 1); eq("R2 rx untouched", rx_empty, 1);

    // R3 R5 R8 R9 fill transmit FIFO while held
    fifo_mode = 1; mctl = 4'b0100; uart_thr_empty = 1;
    for (int i = 0; i < 16; i++) begin
      host_wr = 1; host_wdata = txb(i); #1;
      eq("R5 held load", uart_tx_load, 0);
      if (i == 7) eq("R8 tx_half below", tx_half, 0);
      if (i == 8) eq("R8 tx_half at D/2", tx_half, 1);
      @(negedge clk);
    end
    host_wdata = 8'hEE; #1;
    eq("R8 tx_full", tx_full, 1);
    @(negedge clk); host_wr = 0; #1;
    eq("R9 full kept", tx_full, 1);
    mctl = 4'b0000;
    for (int i = 0; i < 16; i++) begin
      #1;
      eq("R3 load", uart_tx_load, 1);
      eq("R3 order", uart_tx_data, txb(i));
      @(negedge clk);
    end
    #1;
    eq("R9 dropped byte absent", uart_tx_load, 0);
    eq("R3 drained", tx_empty, 1);

    // R4 holding register busy
    uart_thr_empty = 0; host_wr = 1; host_wdata = 8'h44;
    @(negedge clk); host_wr = 0; #1;
    eq("R4 busy no load", uart_tx_load, 0);
    @(negedge clk); #1;
    eq("R4 still queued", tx_empty, 0);
    uart_thr_empty = 1; #1;
    eq("R4 load when free", uart_tx_load, 1); eq("R4 data", uart_tx_data, 8'h44);
    @(negedge clk);

    // R7 receive hold
    mctl = 4'b1000; uart_rx_ready = 1; uart_rx_data = 8'h11; #1;
    eq("R7 no take", uart_rx_take, 0);
    @(negedge clk); #1;
    eq("R7 rx still empty", rx_empty, 1);
    mctl = 4'b0000;

    // R6 R8 R9 fill receive FIFO
    for (int i = 0; i < 16; i++) begin
      uart_rx_data = 8'(8'h20 + i); #1;
      eq("R6 take", uart_rx_take, 1);
      if (i == 7) eq("R8 rx_half below", rx_half, 0);
      if (i == 8) eq("R8 rx_half at D/2", rx_half, 1);
      @(negedge clk);
    end
    #1;
    eq("R8 rx_full_n", rx_full_n, 0);
    eq("R9 no take when full", uart_rx_take, 0);
    uart_rx_ready = 0; host_rd = 1;
    for (int i = 0; i < 16; i++) begin
      #1;
      eq("R6 read order", host_rdata, 8'h20 + i);
      @(negedge clk);
    end
    #1;
    // R10
    eq("R10 empty read", host_rdata, 0);
    @(negedge clk); host_rd = 0; #1;
    eq("R10 stays empty", rx_empty, 1);

    // R11 clear
    mctl = 4'b0100; host_wr = 1; host_wdata = 8'h99;
    uart_rx_ready = 1; uart_rx_data = 8'h66;
    repeat (3) @(negedge clk);
    host_wr = 0; uart_rx_ready = 0; mctl = 4'b0000; fifo_clr = 1; #1;
    eq("R11 no load in clear", uart_tx_load, 0);
    uart_rx_ready = 1; #1;
    eq("R11 no take in clear", uart_rx_take, 0);
    @(negedge clk); fifo_clr = 0; uart_rx_ready = 0; #1;
    eq("R11 tx empty", tx_empty, 1); eq("R11 rx empty", rx_empty, 1);
    eq("R11 nothing to send", uart_tx_load, 0);

    finish_run();
  end
endmodule